// File: doc/BRIEF.md
# Soft-Ramp Volume and Mute Controller

This block sets the attenuation applied to each channel of a stereo sample stream. Two register bytes request a level in whole decibels plus a mute flag. On every sample strobe, one per frame, the block moves each channel's current attenuation toward its target. The current attenuation is given in eighth-decibel units. A downstream gain stage turns it into a linear multiplier.

A two-bit transition mode chooses how a change is applied: at once, at a zero crossing, by a soft ramp of one eighth-decibel per sample, or by a soft ramp whose steps wait for zero crossings. Each channel watches its own signed input samples for zero crossings. If no crossing comes within a bounded number of samples, the change is forced. Each channel also counts runs of static samples (all zeros or all ones) for auto-mute. A link input makes both channels follow the first channel's byte. A mute-control output tells external circuitry when the whole output is silent.

Top module: `vol_ramp_ctl`

## Requirements
- R1: After reset both attenuation outputs are 0 and mute_ctl is 0 while both mute bits are clear.
- R2: Byte bits [6:0] give the level N in dB, and the target is N*8 eighth-dB units. Bit 7 set, or N above MAX_DB, gives the mute target (MAX_DB+1)*8. The outputs never exceed the mute target.
- R3: With tmode = 2'b00, the output equals the target after the first sample strobe.
- R4: With tmode = 2'b01, a pending change is applied, in one jump, on a strobe where the sample is zero or its sign bit differs from the sign bit of that channel's previous strobed sample. Otherwise the output holds.
- R5: In the zero-cross modes (2'b01, 2'b11), a pending change or step with no crossing is forced on the ZC_TO-th strobe after it became pending.
- R6: With tmode = 2'b10, each strobe moves the output by exactly one unit toward the target. A change of D dB therefore completes after 8*D strobes.
- R7: With tmode = 2'b11, one unit step is taken only on a zero-crossing strobe or on a timeout.
- R8: Zero-crossing detection and timeouts are separate for each channel.
- R9: With amute_en = 1, a channel whose samples are all zeros or all ones for AM_LEN consecutive strobes gets the mute target. The first strobe with any other value releases the mute. With amute_en = 0, auto-mute has no effect.
- R10: With link_ab = 1, both channels take their target from vol_a, and vol_b is ignored.
- R11: mute_ctl is 1 while both channels are auto-muted, or while the effective mute bit (bit 7) is set for both channels.
- R12: The attenuation outputs change only in the cycle that follows a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle pulse per sample frame |
| smp_a | input | SW | Channel A signed sample, valid with smp_stb |
| smp_b | input | SW | Channel B signed sample, valid with smp_stb |
| vol_a | input | 8 | Channel A byte: bit 7 mute, [6:0] dB |
| vol_b | input | 8 | Channel B byte: bit 7 mute, [6:0] dB |
| tmode | input | 2 | 00 immediate, 01 zero-cross, 10 ramp, 11 ramp on zero-cross |
| amute_en | input | 1 | Enable auto-mute on static samples |
| link_ab | input | 1 | Both channels follow vol_a |
| att_a | output | QW | Channel A attenuation, eighth-dB units |
| att_b | output | QW | Channel B attenuation, eighth-dB units |
| mute_ctl | output | 1 | External mute request |

## Verification
The bench builds the block with ZC_TO = 16 and AM_LEN = 32 and keeps MAX_DB = 94. The short timeout and short static-run length let the bench reach the forced-change boundary and the auto-mute entry and release many times within a few thousand strobes. Keeping the full level range means ramps up to the mute target and the above-range codes are still covered. Random register changes and sample patterns are mixed with directed runs and compared on every strobe against a bench model.

// File: rtl/vol_ramp_ctl.sv
`timescale 1ns/1ps
module vol_ramp_ctl #(
  parameter int SW     = 24,
  parameter int MAX_DB = 94,
  parameter int ZC_TO  = 512,
  parameter int AM_LEN = 8192,
  localparam int MUTE_Q = (MAX_DB + 1) * 8,
  localparam int QW     = $clog2(MUTE_Q + 1),
  localparam int CW     = $clog2(ZC_TO),
  localparam int AMW    = $clog2(AM_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic [SW-1:0] smp_a,
  input  logic [SW-1:0] smp_b,
  input  logic [7:0]    vol_a,
  input  logic [7:0]    vol_b,
  input  logic [1:0]    tmode,
  input  logic          amute_en,
  input  logic          link_ab,
  output logic [QW-1:0] att_a,
  output logic [QW-1:0] att_b,
  output logic          mute_ctl
);

  logic [1:0][7:0]    vbyte;
  logic [1:0][SW-1:0] smp;
  logic [1:0][QW-1:0] att;
  logic [1:0]         am_hit;

  assign vbyte[0] = vol_a;
  assign vbyte[1] = link_ab ? vol_a : vol_b;
  assign smp[0]   = smp_a;
  assign smp[1]   = smp_b;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [QW-1:0]  tgt, tgt_d, cur, step;
    logic [CW-1:0]  to_cnt, eff;
    logic [AMW-1:0] am_cnt;
    logic           prev_s, zc, tout, pend, stat;

    assign am_hit[c] = amute_en && (am_cnt == AMW'(AM_LEN));
    assign tgt  = (vbyte[c][7] || am_hit[c] || (vbyte[c][6:0] > 7'(MAX_DB)))
                  ? QW'(MUTE_Q) : QW'({vbyte[c][6:0], 3'b000});
    assign zc   = (smp[c] == '0) || (smp[c][SW-1] != prev_s);
    assign stat = (smp[c] == '0) || (&smp[c]);
    assign eff  = (tgt != tgt_d) ? '0 : to_cnt;
    assign tout = (eff == CW'(ZC_TO - 1));
    assign pend = (cur != tgt);
    assign step = (cur < tgt) ? cur + 1'b1 : cur - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur    <= '0;
        tgt_d  <= '0;
        to_cnt <= '0;
        am_cnt <= '0;
        prev_s <= 1'b0;
      end else if (smp_stb) begin
        prev_s <= smp[c][SW-1];
        tgt_d  <= tgt;
        if (!stat)                        am_cnt <= '0;
        else if (am_cnt != AMW'(AM_LEN))  am_cnt <= am_cnt + 1'b1;
        to_cnt <= (tmode[0] && pend && !(zc || tout)) ? eff + 1'b1 : '0;
        if (pend) begin
          case (tmode)
            2'b00:   cur <= tgt;
            2'b01:   if (zc || tout) cur <= tgt;
            2'b10:   cur <= step;
            default: if (zc || tout) cur <= step;
          endcase
        end
      end
    end

    assign att[c] = cur;
  end

  assign att_a    = att[0];
  assign att_b    = att[1];
  assign mute_ctl = (am_hit[0] && am_hit[1]) || (vbyte[0][7] && vbyte[1][7]);

endmodule

module vol_ramp_ctl_chk #(
  parameter int QW     = 10,
  parameter int MUTE_Q = 760
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic [1:0]    tmode,
  input logic [7:0]    vol_a,
  input logic [7:0]    vol_b,
  input logic          link_ab,
  input logic [QW-1:0] att_a,
  input logic [QW-1:0] att_b,
  input logic          mute_ctl
);

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (att_a <= QW'(MUTE_Q)) && (att_b <= QW'(MUTE_Q)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(att_a) && $stable(att_b)));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && tmode == 2'b10) |=>
      ((att_a == $past(att_a)) || (att_a == $past(att_a) + 1'b1) || (att_a + 1'b1 == $past(att_a))));

  p_mutectl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_a[7] && (link_ab || vol_b[7])) |-> mute_ctl);

endmodule

bind vol_ramp_ctl vol_ramp_ctl_chk #(.QW(QW), .MUTE_Q(MUTE_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .tmode(tmode),
  .vol_a(vol_a), .vol_b(vol_b), .link_ab(link_ab),
  .att_a(att_a), .att_b(att_b), .mute_ctl(mute_ctl)
);

// File: tb/vol_ramp_ctl_tb_top.sv
`timescale 1ns/1ps
module vol_ramp_ctl_tb_top;
  localparam int SW = 24, MAX_DB = 94, ZC_TO = 16, AM_LEN = 32;
  localparam int MQ = (MAX_DB + 1) * 8;
  localparam int QW = $clog2(MQ + 1);
  localparam logic [SW-1:0] P  = 24'd1000;
  localparam logic [SW-1:0] N5 = 24'hFFFFFB;
  localparam logic [SW-1:0] N7 = 24'hFFFFF9;
  localparam logic [SW-1:0] N9 = 24'hFFFFF7;
  localparam logic [SW-1:0] ON = 24'hFFFFFF;

  logic clk = 0, rst_n = 0, smp_stb = 0, amute_en = 1, link_ab = 0, mute_ctl;
  logic [SW-1:0] smp_a = P, smp_b = P;
  logic [7:0] vol_a = 0, vol_b = 0;
  logic [1:0] tmode = 2'b10;
  logic [QW-1:0] att_a, att_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_att[2], m_cnt[2], m_amc[2], m_tgd[2];
  bit m_prev[2];

  always #2.5 clk = ~clk;

  vol_ramp_ctl #(.SW(SW), .MAX_DB(MAX_DB), .ZC_TO(ZC_TO), .AM_LEN(AM_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_a(smp_a), .smp_b(smp_b),
    .vol_a(vol_a), .vol_b(vol_b), .tmode(tmode), .amute_en(amute_en),
    .link_ab(link_ab), .att_a(att_a), .att_b(att_b), .mute_ctl(mute_ctl));

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] eff_byte(input int c);
    return (c == 1 && !link_ab) ? vol_b : vol_a;
  endfunction

  function automatic bit am_on(input int c);
    return amute_en && (m_amc[c] == AM_LEN);
  endfunction

  function automatic int exp_mctl();
    logic [7:0] ba = eff_byte(0), bb = eff_byte(1);
    return int'((am_on(0) && am_on(1)) || (ba[7] && bb[7]));
  endfunction

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      logic [7:0] b = eff_byte(c);
      logic [SW-1:0] s = c ? smp_b : smp_a;
      int tgt = (b[7] || am_on(c) || b[6:0] > MAX_DB) ? MQ : int'(b[6:0]) * 8;
      bit zc = (s == '0) || (s[SW-1] != m_prev[c]);
      int eff = (tgt != m_tgd[c]) ? 0 : m_cnt[c];
      bit fire = zc || (eff == ZC_TO - 1);
      bit pend = m_att[c] != tgt;
      int stp = (m_att[c] < tgt) ? m_att[c] + 1 : m_att[c] - 1;
      m_cnt[c] = (tmode[0] && pend && !fire) ? eff + 1 : 0;
      if (pend)
        case (tmode)
          2'b00: m_att[c] = tgt;
          2'b01: if (fire) m_att[c] = tgt;
          2'b10: m_att[c] = stp;
          default: if (fire) m_att[c] = stp;
        endcase
      m_prev[c] = s[SW-1];
      m_tgd[c] = tgt;
      if (s == '0 || &s) begin
        if (m_amc[c] != AM_LEN) m_amc[c]++;
      end else m_amc[c] = 0;
    end
  endtask

  task automatic strobe(input logic [SW-1:0] sa, input logic [SW-1:0] sb);
    @(negedge clk);
    smp_a = sa; smp_b = sb; smp_stb = 1;
    model_step();
    @(negedge clk);
    smp_stb = 0;
    chk("model att_a", int'(att_a), m_att[0]);
    chk("model att_b", int'(att_b), m_att[1]);
    chk("model mute_ctl", int'(mute_ctl), exp_mctl());
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got 0 expected 1 (run end)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin m_att[c]=0; m_cnt[c]=0; m_amc[c]=0; m_tgd[c]=0; m_prev[c]=0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 att_a", int'(att_a), 0);
    chk("R1 att_b", int'(att_b), 0);
    chk("R1 mute_ctl", int'(mute_ctl), 0);

    vol_a = 10;
    repeat (79) strobe(P, P);
    chk("R6 ramp part", int'(att_a), 79);
    strobe(P, P);
    chk("R6 ramp done 8xD", int'(att_a), 80);
    strobe(P, P);
    chk("R6 ramp settled", int'(att_a), 80);

    tmode = 2'b00; vol_a = 20;
    strobe(P, P);
    chk("R3 immediate", int'(att_a), 160);
    vol_a = 100; strobe(P, P);
    chk("R2 above range mutes", int'(att_a), MQ);
    vol_a = 8'h85; strobe(P, P);
    chk("R2 mute bit", int'(att_a), MQ);
    vol_a = 94; strobe(P, P);
    chk("R2 max level", int'(att_a), 752);

    tmode = 2'b01; vol_a = 0;
    repeat (3) strobe(P, P);
    chk("R4 wait for crossing", int'(att_a), 752);
    strobe(N5, P);
    chk("R4 apply on crossing", int'(att_a), 0);

    vol_a = 5;
    repeat (15) strobe(N7, P);
    chk("R5 before timeout", int'(att_a), 0);
    strobe(N7, P);
    chk("R5 forced at ZC_TO", int'(att_a), 40);

    tmode = 2'b11; vol_a = 6;
    strobe(N7, P);
    chk("R7 no crossing holds", int'(att_a), 40);
    strobe(P, P);
    chk("R7 step on crossing", int'(att_a), 41);
    strobe(P, P);
    chk("R7 one step only", int'(att_a), 41);

    tmode = 2'b01; vol_a = 0; vol_b = 3;
    strobe(P, N9);
    chk("R8 A no crossing", int'(att_a), 41);
    chk("R8 B own crossing", int'(att_b), 24);

    link_ab = 1; tmode = 2'b00; vol_a = 12; vol_b = 50;
    strobe(P, P);
    chk("R10 A from vol_a", int'(att_a), 96);
    chk("R10 B from vol_a", int'(att_b), 96);
    vol_b = 70; strobe(P, P);
    chk("R10 vol_b ignored", int'(att_b), 96);

    link_ab = 0; vol_a = 30; vol_b = 12;
    repeat (3) @(negedge clk);
    chk("R12 no strobe no change", int'(att_a), 96);
    strobe(P, P);
    chk("R12 change on strobe", int'(att_a), 240);

    vol_a = 8'h80; vol_b = 8'h80; #1;
    chk("R11 both mute bits", int'(mute_ctl), 1);
    vol_b = 0; #1;
    chk("R11 one mute bit", int'(mute_ctl), 0);
    vol_a = 0;

    repeat (31) strobe('0, ON);
    chk("R9 before run length", int'(mute_ctl), 0);
    chk("R9 A level before", int'(att_a), 0);
    strobe('0, ON);
    chk("R9 mute_ctl on both", int'(mute_ctl), 1);
    strobe('0, ON);
    chk("R9 A muted", int'(att_a), MQ);
    chk("R9 B muted", int'(att_b), MQ);
    strobe(24'd1, ON);
    chk("R9 release mute_ctl", int'(mute_ctl), 0);
    strobe(24'd1, ON);
    chk("R9 A released", int'(att_a), 0);
    chk("R9 B still muted", int'(att_b), MQ);
    amute_en = 0;
    strobe(24'd1, ON);
    chk("R9 disabled no effect", int'(att_b), 0);

    begin
      bit qa = 0, qb = 0;
      amute_en = 1;
      for (int i = 0; i < 3000; i++) begin
        logic [SW-1:0] sa, sb;
        if ($urandom % 20 == 0) tmode = 2'($urandom);
        if ($urandom % 30 == 0) vol_a = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 100);
        if ($urandom % 30 == 0) vol_b = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 100);
        if ($urandom % 60 == 0) link_ab = ~link_ab;
        if ($urandom % 80 == 0) amute_en = ~amute_en;
        if ($urandom % 40 == 0) qa = ~qa;
        if ($urandom % 40 == 0) qb = ~qb;
        sa = qa ? (($urandom % 2) ? '0 : ON) : (($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 64) - 24'd32);
        sb = qb ? '0 : 24'($urandom);
        strobe(sa, sb);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule